// File: doc/BRIEF.md
# Microcoded Shared-Bus Processor Core

This block is a minimal processor core in which the program counter, instruction register, register-index latch, register file, the two ALU operand latches, the memory address register and the memory port all talk over one 32-bit bus. A control ROM steps through states. Each state gives a complete control word: which unit drives the bus, which units capture it, the ALU function, the register-file and memory strobes, and the state that follows.

The core fetches a word from the address held in the PC and advances the PC by four through the ALU. It then dispatches on the instruction fields. It executes a register-register add, and an add whose first operand comes from memory at the address held in a register. Every other encoding is skipped. Reads on the memory port stall the sequencer until the memory raises ready. For observation, the bus value, the register-write strobe and the latched register index are brought out as ports.

Top module: `mc_bus_core`

## Requirements
- R1: Reset (synchronous, active high) clears the PC to 0 and places the sequencer in its first fetch state: while reset is held the bus carries 0, and no read or register write is issued. The first read after release is at address 0.
- R2: In any cycle at most one unit drives the bus. The bus value is the OR of all gated sources, so a second driver would corrupt every transferred value.
- R3: Fetch uses four states. It reads the word at the PC into the instruction register and then adds 4 to the PC. Instructions are therefore read at consecutive word addresses 0, 4, 8, and so on.
- R4: While a memory read is asserted and ready is low, the state holds and no latch captures the bus. A read with latency L (ready L cycles after the read starts) lengthens its state by exactly L cycles.
- R5: Opcode bits [31:26] = 0 with funct bits [5:0] = 0x20 selects ADD. It writes RF[rd] = RF[rs] + RF[rt], with rs in bits [25:21], rt in [20:16] and rd in [15:11]. The write strobe is raised in the sixth state after fetch, with the index equal to rd and the sum on the bus.
- R6: Opcode 0 with funct 0x30 selects ADDM. It places RF[rs] on the memory address, reads that byte address, and writes RF[rd] = M[RF[rs]] + RF[rt] in its seventh state (plus the read latency).
- R7: Register 0 always reads as zero. A write aimed at it is strobed but has no effect.
- R8: Any other opcode or funct performs no register write and no data read. The next fetch follows directly at PC + 4.
- R9: When rd equals rs or rt, the operands are the values held before the write.
- R10: With read latency L, an ADD instruction takes 10 + L cycles, an ADDM 11 + 2L cycles, and a skipped encoding 4 + L cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address from the memory address register |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request (never raised by the current microcode) |
| mem_wdata | output | 32 | Write data, equal to the bus |
| mem_rdata | input | 32 | Read data, driven onto the bus while the read is granted |
| mem_ready | input | 1 | Read data valid |
| bus_value | output | 32 | Current value on the shared bus |
| rf_write | output | 1 | Register-file write strobe |
| rf_index | output | 5 | Latched register index |

## Verification
Two events can fall in the same cycle: the ready handshake and the capture of the returned word. With zero latency, ready arrives in the very cycle the read is raised. The stall and the latch then coincide, and the state must advance at once. The bench replays one program of ADD, ADDM and skipped encodings at latencies 0 to 3. A bench-side instruction model predicts the exact cycle, address and value of every read completion and every register write. A stall that is lost, doubled or latched early therefore shows up as a timing or value mismatch. Cases where the destination is register 0, or equals a source, are placed in the program on purpose.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int unsigned PC_STEP = 4;
  localparam logic [5:0]  OPC_REG = 6'h00;
  localparam logic [5:0]  FN_ADD  = 6'h20;
  localparam logic [5:0]  FN_ADDM = 6'h30;
  localparam logic [4:0]  LSB_RS  = 5'd21;
  localparam logic [4:0]  LSB_RT  = 5'd16;
  localparam logic [4:0]  LSB_RD  = 5'd11;

  typedef enum logic [4:0] {
    S_F0, S_F1, S_F2, S_F3,
    S_A0, S_A1, S_A2, S_A3, S_A4, S_A5,
    S_M0, S_M1, S_M2, S_M3, S_M4, S_M5, S_M6
  } st_t;

  typedef enum logic [1:0] {ALU_NOP, ALU_ADD, ALU_INC} alu_t;

  typedef struct packed {
    logic       pc_ld;
    logic       pc_drv;
    logic       ir_ld;
    logic       ir_drv;
    logic       a_ld;
    logic       b_ld;
    alu_t       alu_fn;
    logic       alu_drv;
    logic [4:0] fld_lsb;
    logic       idx_ld;
    logic       rf_rd;
    logic       rf_wr;
    logic       rf_drv;
    logic       mar_ld;
    logic       mem_rd;
    logic       mem_wr;
    logic       mem_drv;
    logic       dispatch;
    st_t        nxt;
  } ctl_t;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_t          fn,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  always_comb begin
    unique case (fn)
      ALU_ADD: y = a + b;
      ALU_INC: y = a + DW'(PC_STEP);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int DW    = 32,
  parameter int NREG  = 32,
  localparam int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rq
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && idx != '0) regs[idx] <= wd;
  end

  assign rq = (idx == '0) ? '0 : regs[idx];

  // R7
  zero_read_chk: assert property (@(posedge clk) disable iff (rst)
    (idx == '0) |-> (rq == '0));
endmodule

// File: rtl/mc_seq.sv
module mc_seq
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mem_ready,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       cw,
  output logic       adv
);
  st_t state, nxt_state;

  always_comb begin
    cw = '0;
    cw.nxt = S_F0;
    unique case (state)
      S_F0: begin cw.pc_drv = 1'b1; cw.mar_ld = 1'b1; cw.nxt = S_F1; end
      S_F1: begin cw.mem_rd = 1'b1; cw.mem_drv = 1'b1; cw.ir_ld = 1'b1; cw.nxt = S_F2; end
      S_F2: begin cw.pc_drv = 1'b1; cw.a_ld = 1'b1; cw.nxt = S_F3; end
      S_F3: begin cw.alu_fn = ALU_INC; cw.alu_drv = 1'b1; cw.pc_ld = 1'b1; cw.dispatch = 1'b1; end
      S_A0: begin cw.ir_drv = 1'b1; cw.fld_lsb = LSB_RS; cw.idx_ld = 1'b1; cw.nxt = S_A1; end
      S_A1: begin cw.rf_rd = 1'b1; cw.rf_drv = 1'b1; cw.a_ld = 1'b1; cw.nxt = S_A2; end
      S_A2: begin cw.ir_drv = 1'b1; cw.fld_lsb = LSB_RT; cw.idx_ld = 1'b1; cw.nxt = S_A3; end
      S_A3: begin cw.rf_rd = 1'b1; cw.rf_drv = 1'b1; cw.b_ld = 1'b1; cw.nxt = S_A4; end
      S_A4: begin cw.ir_drv = 1'b1; cw.fld_lsb = LSB_RD; cw.idx_ld = 1'b1; cw.nxt = S_A5; end
      S_A5: begin cw.alu_fn = ALU_ADD; cw.alu_drv = 1'b1; cw.rf_wr = 1'b1; end
      S_M0: begin cw.ir_drv = 1'b1; cw.fld_lsb = LSB_RS; cw.idx_ld = 1'b1; cw.nxt = S_M1; end
      S_M1: begin cw.rf_rd = 1'b1; cw.rf_drv = 1'b1; cw.mar_ld = 1'b1; cw.nxt = S_M2; end
      S_M2: begin cw.mem_rd = 1'b1; cw.mem_drv = 1'b1; cw.a_ld = 1'b1; cw.nxt = S_M3; end
      S_M3: begin cw.ir_drv = 1'b1; cw.fld_lsb = LSB_RT; cw.idx_ld = 1'b1; cw.nxt = S_M4; end
      S_M4: begin cw.rf_rd = 1'b1; cw.rf_drv = 1'b1; cw.b_ld = 1'b1; cw.nxt = S_M5; end
      S_M5: begin cw.ir_drv = 1'b1; cw.fld_lsb = LSB_RD; cw.idx_ld = 1'b1; cw.nxt = S_M6; end
      S_M6: begin cw.alu_fn = ALU_ADD; cw.alu_drv = 1'b1; cw.rf_wr = 1'b1; end
      default: cw.nxt = S_F0;
    endcase
  end

  assign adv = !(cw.mem_rd && !mem_ready);

  always_comb begin
    nxt_state = cw.nxt;
    if (cw.dispatch && opcode == OPC_REG) begin
      if (funct == FN_ADD)       nxt_state = S_A0;
      else if (funct == FN_ADDM) nxt_state = S_M0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      state <= S_F0;
    else if (adv) state <= nxt_state;
  end

  // R1
  reset_fetch_chk: assert property (@(posedge clk)
    rst |=> (state == S_F0));
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cw.mem_rd && !mem_ready) |=> (cw.mem_rd && $stable(state)));
endmodule

// File: rtl/mc_bus_core.sv
module mc_bus_core
  import mc_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic [DW-1:0] bus_value,
  output logic          rf_write,
  output logic [IW-1:0] rf_index
);
  ctl_t          cw;
  logic          adv;
  logic [DW-1:0] pc, ir, a_q, b_q, mar, bus, alu_y, rf_q, ir_sh, ir_fld;
  logic [IW-1:0] idx;

  mc_seq u_seq (
    .clk(clk), .rst(rst), .mem_ready(mem_ready),
    .opcode(ir[31:26]), .funct(ir[5:0]), .cw(cw), .adv(adv)
  );

  mc_alu #(.DW(DW)) u_alu (.fn(cw.alu_fn), .a(a_q), .b(b_q), .y(alu_y));

  mc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(cw.rf_wr && adv), .idx(idx), .wd(bus), .rq(rf_q)
  );

  assign ir_sh  = ir >> cw.fld_lsb;
  assign ir_fld = {{(DW-IW){1'b0}}, ir_sh[IW-1:0]};

  assign bus = ({DW{cw.pc_drv}}  & pc)
             | ({DW{cw.ir_drv}}  & ir_fld)
             | ({DW{cw.alu_drv}} & alu_y)
             | ({DW{cw.rf_drv}}  & rf_q)
             | ({DW{cw.mem_drv}} & mem_rdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      ir  <= '0;
      idx <= '0;
      a_q <= '0;
      b_q <= '0;
      mar <= '0;
    end else if (adv) begin
      if (cw.pc_ld)  pc  <= bus;
      if (cw.ir_ld)  ir  <= bus;
      if (cw.idx_ld) idx <= bus[IW-1:0];
      if (cw.a_ld)   a_q <= bus;
      if (cw.b_ld)   b_q <= bus;
      if (cw.mar_ld) mar <= bus;
    end
  end

  assign mem_addr  = mar;
  assign mem_rd    = cw.mem_rd;
  assign mem_wr    = cw.mem_wr;
  assign mem_wdata = bus;
  assign bus_value = bus;
  assign rf_write  = cw.rf_wr;
  assign rf_index  = idx;

  // R2
  one_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cw.pc_drv, cw.ir_drv, cw.alu_drv, cw.rf_drv, cw.mem_drv}));
  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cw.pc_ld && adv) |=> (pc == $past(pc) + DW'(PC_STEP)));
  // R4
  stall_latch_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(ir) && $stable(a_q)));
endmodule

// File: tb/tb_mc_bus_core.sv
`timescale 1ns/1ps
module tb_mc_bus_core;
  localparam int NPROG = 131;
  localparam int NEV   = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, bus_value;
  logic        mem_rd, mem_wr, mem_ready, rf_write;
  logic [4:0]  rf_index;

  always #2 clk = ~clk;

  mc_bus_core dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .bus_value(bus_value), .rf_write(rf_write), .rf_index(rf_index)
  );

  logic [31:0] mem [256];
  int lat = 0, wcnt = 0, cyc = 0;
  int checks = 0, errors = 0;
  bit running = 0;

  assign mem_rdata = mem[mem_addr[9:2]];
  assign mem_ready = mem_rd && (wcnt >= lat);

  always @(posedge clk) begin
    wcnt <= (rst || !mem_rd || mem_ready) ? 0 : wcnt + 1;
    cyc  <= rst ? 0 : cyc + 1;
  end

  int          rd_cyc [NEV];
  logic [31:0] rd_adr [NEV];
  string       rd_tag [NEV];
  int          wr_cyc [NEV];
  logic [4:0]  wr_idx [NEV];
  logic [31:0] wr_val [NEV];
  string       wr_tag [NEV];
  int nrd, nwr, rdp, wrp;

  function automatic logic [31:0] enc(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt, logic [4:0] rd);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction

  task automatic build_model(int L);
    logic [31:0] r [32];
    logic [31:0] pc, w, v;
    int s, f;
    string prev;
    for (int i = 0; i < 32; i++) r[i] = '0;
    pc = 0; s = 0; nrd = 0; nwr = 0; prev = "R3 R10";
    for (int n = 0; n < NPROG; n++) begin
      rd_cyc[nrd] = s + 1 + L; rd_adr[nrd] = pc; rd_tag[nrd] = prev; nrd++;
      f = s + 4 + L; w = mem[pc[9:2]]; pc = pc + 4; prev = "R3 R10";
      if (w[31:26] == 6'd0 && w[5:0] == 6'h20) begin
        v = r[w[25:21]] + r[w[20:16]];
        wr_cyc[nwr] = f + 5; wr_idx[nwr] = w[15:11]; wr_val[nwr] = v;
        wr_tag[nwr] = (w[15:11] == 0) ? "R5 R7" :
                      (w[15:11] == w[25:21] || w[15:11] == w[20:16]) ? "R5 R9" : "R2 R5";
        nwr++;
        if (w[15:11] != 0) r[w[15:11]] = v;
        s = f + 6;
      end else if (w[31:26] == 6'd0 && w[5:0] == 6'h30) begin
        rd_cyc[nrd] = f + 2 + L; rd_adr[nrd] = r[w[25:21]]; rd_tag[nrd] = "R4 R6"; nrd++;
        v = mem[r[w[25:21]][9:2]] + r[w[20:16]];
        wr_cyc[nwr] = f + 6 + L; wr_idx[nwr] = w[15:11]; wr_val[nwr] = v;
        wr_tag[nwr] = (w[15:11] == 0) ? "R6 R7" :
                      (w[15:11] == w[25:21] || w[15:11] == w[20:16]) ? "R6 R9" : "R6 R10";
        nwr++;
        if (w[15:11] != 0) r[w[15:11]] = v;
        s = f + 7 + L;
      end else begin
        prev = "R8 R10";
        s = f;
      end
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      if (mem_rd && mem_ready && rdp < nrd) begin
        checks++;
        if (cyc != rd_cyc[rdp] || mem_addr != rd_adr[rdp]) begin
          errors++;
          $display("FAIL %s read %0d: cycle %0d addr %h, expected cycle %0d addr %h (latency %0d)",
                   rd_tag[rdp], rdp, cyc, mem_addr, rd_cyc[rdp], rd_adr[rdp], lat);
        end
        rdp++;
      end
      if (rf_write && wrp < nwr) begin
        checks++;
        if (cyc != wr_cyc[wrp] || rf_index != wr_idx[wrp] || bus_value != wr_val[wrp]) begin
          errors++;
          $display("FAIL %s write %0d: cycle %0d r%0d=%h, expected cycle %0d r%0d=%h (latency %0d)",
                   wr_tag[wrp], wrp, cyc, rf_index, bus_value, wr_cyc[wrp], wr_idx[wrp], wr_val[wrp], lat);
        end
        wrp++;
      end
    end
  end

  initial begin
    logic [15:0] lf;
    logic [4:0]  rs, rt, rd;
    int k, sel, guard;
    // program: chain that gives every register a known value, then mixed operations
    for (int i = 1; i < 32; i++) mem[i-1] = enc(6'h30, 5'(i-1), 5'(i-1), 5'(i));
    lf = 16'hACE1;
    for (int n = 31; n < NPROG; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      rs = lf[4:0]; rt = lf[9:5]; rd = lf[14:10];
      if (n % 7 == 0)  rd = rs;
      if (n % 11 == 0) rd = rt;
      if (n % 13 == 0) rd = 5'd0;
      sel = int'(lf) % 10;
      if (sel < 4)       mem[n] = enc(6'h20, rs, rt, rd);
      else if (sel < 8)  mem[n] = enc(6'h30, rs, rt, rd);
      else if (sel == 8) mem[n] = enc(6'h21, rs, rt, rd);
      else               mem[n] = {6'h02, rs, rt, rd, 11'h020};
    end
    for (int i = NPROG; i < 256; i++) mem[i] = (32'(i) * 32'h9E3779B9) ^ 32'(i);

    for (int L = 0; L < 4; L++) begin
      rst = 1'b1; running = 0; lat = L;
      repeat (3) @(negedge clk);
      checks++;
      if (bus_value != 0 || mem_rd || rf_write) begin
        errors++;
        $display("FAIL R1 reset state: bus %h rd %b wr %b, expected 0 0 0", bus_value, mem_rd, rf_write);
      end
      build_model(L);
      rdp = 0; wrp = 0;
      rst = 1'b0; running = 1;
      guard = 0;
      while ((rdp < nrd || wrp < nwr) && guard < 20000) begin
        @(negedge clk);
        guard++;
      end
      running = 0;
      if (guard >= 20000) begin
        checks++; errors++;
        $display("FAIL watchdog latency %0d: reads %0d/%0d writes %0d/%0d", L, rdp, nrd, wrp, nwr);
      end
    end
    k = 0;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule